// File: doc/BRIEF.md
# Staged Thread Release Sequencer

After reset, every hardware thread of an eight-core, eight-threads-per-core cluster sits parked. This block brings the enabled ones into the running state one at a time. It keeps a 64-bit running-status vector that it updates with write-1-to-set pulses, one thread per pulse. Each pulse is announced on a one-cycle strobe that carries the thread index.

Release happens in three stages. The first thread released is the lowest enabled thread of the lowest populated core. Next comes the lowest enabled thread of each remaining populated core, with the cores taken in pseudo-random order. Last, every other enabled thread is released in pseudo-random order. A 16-bit LFSR drives every random choice. It picks a rotating starting point for each search, so a pick never lands on a thread that was already released, and it also sets a bounded gap between consecutive releases. Nothing is released until an external core-cycle counter passes a start gate. The gate is later when the forced power-on-state option is selected.

The release strobe is a pure output event with no ready and no back-pressure. A consumer that must see every release has to accept one strobe per clock, because with a zero gap two strobes can come back to back.

Top module: `thread_release_seq`

## Requirements
- R1: Thread index t (0..63) belongs to core t/8 and local thread t%8. `rel_idx` carries t, and that release sets bit t of `run_status`. A strobe only ever names a thread whose `enable_mask` bit is 1.
- R2: Releases are held back until `cycle_cnt` reaches 12, or 38 when `por_force` is 1. With a counter that steps by one each clock, the first strobe appears in the cycle where `cycle_cnt` equals the gate plus one.
- R3: With an all-zero `enable_mask`, no strobe is produced, `run_status` stays 0, and `done` rises at the gate.
- R4: The first release is the lowest enabled local thread of the lowest-numbered core that has any enabled thread.
- R5: Releases 2..K, where K is the number of populated cores, each release the lowest enabled thread of a different populated core other than the first one. The cores are taken in pseudo-random order.
- R6: After that stage, each enabled thread that has not yet been released is released. Every enabled thread is released exactly once, so the total strobe count equals the popcount of the mask.
- R7: Consecutive strobes are separated by D+1 clocks, and D lies in [`delay_min`, `delay_max`]. When `delay_max` < `delay_min`, D equals `delay_min`.
- R8: Each strobe sets exactly one new bit of `run_status`, the bit at `rel_idx`, and leaves every other bit unchanged. Between strobes `run_status` holds. Disabled threads never gain a bit.
- R9: `done` rises in the cycle in which `run_status` becomes equal to `enable_mask`. It stays high until reset, and no strobe follows it.
- R10: While reset is active, `rel_valid`, `run_status` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_mask | input | 64 | Threads to release; bit t is thread t |
| por_force | input | 1 | Selects the later start gate |
| cycle_cnt | input | 8 | Core cycle count since reset |
| delay_min | input | 8 | Lower bound of the inter-release gap |
| delay_max | input | 8 | Upper bound of the inter-release gap |
| rel_valid | output | 1 | One-cycle strobe per release |
| rel_idx | output | 6 | Index of the thread being released |
| run_status | output | 64 | Running-status vector (write-1-to-set) |
| done | output | 1 | All enabled threads released |

## Verification
The checker assumes that `enable_mask`, `por_force` and both delay bounds are stable from reset until `done`, and that `cycle_cnt` never decreases. The subset, gate and completion properties all depend on those assumptions. The bench changes these inputs only while reset is held. It drives `cycle_cnt` as a counter that starts from zero at reset release, steps once per clock, and saturates instead of wrapping. Masks are swept across corner shapes (empty, single bit at each end, full, one thread per core, threads sparse across cores) and pseudo-random patterns. The delay bounds cover zero, equal bounds, open ranges and an inverted pair.

// File: rtl/thread_rel_pkg.sv
package thread_rel_pkg;

  localparam int          RND_W    = 16;
  localparam logic [15:0] RND_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    ST_GATE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } rel_state_e;

endpackage

// File: rtl/thread_rel_lfsr.sv
module thread_rel_lfsr
  import thread_rel_pkg::*;
#(
  parameter logic [RND_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [RND_W-1:0] state
);

  logic [RND_W-1:0] nxt;

  always_comb begin
    nxt = state >> 1;
    if (state[0]) nxt = nxt ^ RND_TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= (SEED == '0) ? RND_W'(1) : SEED;
    else        state <= nxt;
  end

endmodule

// File: rtl/thread_rel_lowfind.sv
module thread_rel_lowfind #(
  parameter int NC  = 8,
  parameter int TPC = 8,
  localparam int NT   = NC * TPC,
  localparam int LT_W = $clog2(TPC),
  localparam int CW   = $clog2(NC)
) (
  input  logic [NT-1:0]      mask,
  output logic [NC-1:0]      core_any,
  output logic [NC*LT_W-1:0] low_local,
  output logic [CW-1:0]      low_core
);

  for (genvar c = 0; c < NC; c++) begin : g_core
    logic [TPC-1:0]  slice;
    logic [LT_W-1:0] lo;
    assign slice = mask[c*TPC +: TPC];
    always_comb begin
      lo = '0;
      for (int t = TPC - 1; t >= 0; t--) begin
        if (slice[t]) lo = LT_W'(t);
      end
    end
    assign core_any[c]                 = |slice;
    assign low_local[c*LT_W +: LT_W]   = lo;
  end

  always_comb begin
    low_core = '0;
    for (int c = NC - 1; c >= 0; c--) begin
      if (core_any[c]) low_core = CW'(c);
    end
  end

endmodule

// File: rtl/thread_rel_rotpick.sv
module thread_rel_rotpick #(
  parameter int N = 64,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      logic [IW-1:0] pos;
      pos = start + IW'(k);
      if (!hit && req[pos]) begin
        hit = 1'b1;
        idx = pos;
      end
    end
  end

endmodule

// File: rtl/thread_rel_gap.sv
module thread_rel_gap #(
  parameter int DW = 8,
  localparam int PW = 2 * DW + 1,
  localparam int SW = DW + 1
) (
  input  logic [DW-1:0] dmin,
  input  logic [DW-1:0] dmax,
  input  logic [DW-1:0] rnd,
  output logic [DW-1:0] gap
);

  logic [SW-1:0] span1;
  logic [DW-1:0] off;

  always_comb begin
    if (dmax > dmin) span1 = {1'b0, dmax} - {1'b0, dmin} + SW'(1);
    else             span1 = SW'(1);
    off = DW'((PW'(rnd) * PW'(span1)) >> DW);
    gap = dmin + off;
  end

endmodule

// File: rtl/thread_release_seq.sv
module thread_release_seq
  import thread_rel_pkg::*;
#(
  parameter int NUM_CORES        = 8,
  parameter int THREADS_PER_CORE = 8,
  parameter int DLY_W            = 8,
  parameter int CYC_W            = 8,
  parameter int EARLY_GATE       = 12,
  parameter int POR_GATE         = 38,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                                                  clk,
  input  logic                                                  rst_n,
  input  logic [NUM_CORES*THREADS_PER_CORE-1:0]                 enable_mask,
  input  logic                                                  por_force,
  input  logic [CYC_W-1:0]                                      cycle_cnt,
  input  logic [DLY_W-1:0]                                      delay_min,
  input  logic [DLY_W-1:0]                                      delay_max,
  output logic                                                  rel_valid,
  output logic [$clog2(NUM_CORES*THREADS_PER_CORE)-1:0]         rel_idx,
  output logic [NUM_CORES*THREADS_PER_CORE-1:0]                 run_status,
  output logic                                                  done
);

  localparam int NT    = NUM_CORES * THREADS_PER_CORE;
  localparam int IDX_W = $clog2(NT);
  localparam int CW    = $clog2(NUM_CORES);
  localparam int LT_W  = $clog2(THREADS_PER_CORE);

  rel_state_e         state_q;
  logic [NT-1:0]      en_q;
  logic [NT-1:0]      run_q;
  logic [NUM_CORES-1:0] core_todo_q;
  logic [DLY_W-1:0]   cnt_q;
  logic               rel_v_q;
  logic [IDX_W-1:0]   rel_idx_q;

  logic [RND_W-1:0]   rnd;
  logic [NT-1:0]      pending;
  logic [NUM_CORES-1:0] core_any;
  logic [NUM_CORES*LT_W-1:0] low_local;
  logic [CW-1:0]      low_core;
  logic               core_hit, thr_hit;
  logic [CW-1:0]      core_pick;
  logic [IDX_W-1:0]   thr_pick;
  logic [DLY_W-1:0]   gap;
  logic               gate_ok;
  logic [IDX_W-1:0]   first_idx, wait_idx, fire_idx;
  logic [NT-1:0]      fire_bit;
  logic               last_fire;

  thread_rel_lfsr #(.SEED(LFSR_SEED)) u_rnd (
    .clk   (clk),
    .rst_n (rst_n),
    .state (rnd)
  );

  thread_rel_lowfind #(.NC(NUM_CORES), .TPC(THREADS_PER_CORE)) u_low (
    .mask      (en_q),
    .core_any  (core_any),
    .low_local (low_local),
    .low_core  (low_core)
  );

  thread_rel_rotpick #(.N(NUM_CORES)) u_core_pick (
    .req   (core_todo_q),
    .start (rnd[RND_W-1 -: CW]),
    .hit   (core_hit),
    .idx   (core_pick)
  );

  assign pending = en_q & ~run_q;

  thread_rel_rotpick #(.N(NT)) u_thr_pick (
    .req   (pending),
    .start (rnd[RND_W-1-CW -: IDX_W]),
    .hit   (thr_hit),
    .idx   (thr_pick)
  );

  thread_rel_gap #(.DW(DLY_W)) u_gap (
    .dmin (delay_min),
    .dmax (delay_max),
    .rnd  (rnd[DLY_W-1:0]),
    .gap  (gap)
  );

  assign gate_ok = por_force ? (cycle_cnt >= CYC_W'(POR_GATE))
                             : (cycle_cnt >= CYC_W'(EARLY_GATE));

  assign first_idx = {low_core, low_local[low_core*LT_W +: LT_W]};

  always_comb begin
    if (core_hit) wait_idx = {core_pick, low_local[core_pick*LT_W +: LT_W]};
    else          wait_idx = thr_pick;
  end

  assign fire_idx  = (state_q == ST_FIRST) ? first_idx : wait_idx;
  assign fire_bit  = {{(NT-1){1'b0}}, 1'b1} << fire_idx;
  assign last_fire = (pending & ~fire_bit) == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_GATE;
      en_q        <= '0;
      run_q       <= '0;
      core_todo_q <= '0;
      cnt_q       <= '0;
      rel_v_q     <= 1'b0;
      rel_idx_q   <= '0;
    end else begin
      rel_v_q <= 1'b0;
      unique case (state_q)
        ST_GATE: begin
          if (gate_ok) begin
            en_q    <= enable_mask;
            state_q <= (|enable_mask) ? ST_FIRST : ST_DONE;
          end
        end
        ST_FIRST: begin
          rel_v_q         <= 1'b1;
          rel_idx_q       <= fire_idx;
          run_q[fire_idx] <= 1'b1;
          core_todo_q     <= core_any & ~({{(NUM_CORES-1){1'b0}}, 1'b1} << low_core);
          cnt_q           <= gap;
          state_q         <= last_fire ? ST_DONE : ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
          end else if (core_hit || thr_hit) begin
            rel_v_q         <= 1'b1;
            rel_idx_q       <= fire_idx;
            run_q[fire_idx] <= 1'b1;
            if (core_hit) core_todo_q[core_pick] <= 1'b0;
            cnt_q           <= gap;
            if (last_fire) state_q <= ST_DONE;
          end else begin
            state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          state_q <= ST_DONE;
        end
        default: state_q <= ST_GATE;
      endcase
    end
  end

  assign rel_valid  = rel_v_q;
  assign rel_idx    = rel_idx_q;
  assign run_status = run_q;
  assign done       = (state_q == ST_DONE);

endmodule

// File: rtl/thread_rel_chk.sv
module thread_rel_chk #(
  parameter int NT         = 64,
  parameter int DLY_W      = 8,
  parameter int CYC_W      = 8,
  parameter int EARLY_GATE = 12,
  parameter int POR_GATE   = 38,
  localparam int IDX_W = $clog2(NT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NT-1:0]    enable_mask,
  input logic             por_force,
  input logic [CYC_W-1:0] cycle_cnt,
  input logic [DLY_W-1:0] delay_min,
  input logic [DLY_W-1:0] delay_max,
  input logic             rel_valid,
  input logic [IDX_W-1:0] rel_idx,
  input logic [NT-1:0]    run_status,
  input logic             done
);

  logic [DLY_W:0]   since_q;
  logic             seen_q;
  logic [DLY_W-1:0] dmax_eff;
  logic [NT-1:0]    idx_bit;

  assign dmax_eff = (delay_max < delay_min) ? delay_min : delay_max;
  assign idx_bit  = {{(NT-1){1'b0}}, 1'b1} << rel_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (rel_valid) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (since_q != '1) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R8
  w1s_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (run_status == ($past(run_status) | idx_bit)) &&
                  (($past(run_status) & idx_bit) == '0));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rel_valid |-> $stable(run_status));

  // R1
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_status & ~enable_mask) == '0);

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (cycle_cnt >= (por_force ? CYC_W'(POR_GATE) : CYC_W'(EARLY_GATE))));

  // R7
  gap_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && seen_q) |-> (since_q >= {1'b0, delay_min}) && (since_q <= {1'b0, dmax_eff}));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9
  done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_status == enable_mask));

  // R9
  quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !rel_valid);

endmodule

bind thread_release_seq thread_rel_chk #(
  .NT         (NUM_CORES * THREADS_PER_CORE),
  .DLY_W      (DLY_W),
  .CYC_W      (CYC_W),
  .EARLY_GATE (EARLY_GATE),
  .POR_GATE   (POR_GATE)
) u_thread_rel_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable_mask (enable_mask),
  .por_force   (por_force),
  .cycle_cnt   (cycle_cnt),
  .delay_min   (delay_min),
  .delay_max   (delay_max),
  .rel_valid   (rel_valid),
  .rel_idx     (rel_idx),
  .run_status  (run_status),
  .done        (done)
);

// File: tb/thread_release_seq_bench.sv
module thread_release_seq_bench;

  localparam int NT = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] enable_mask = '0;
  logic        por_force = 1'b0;
  logic [7:0]  cycle_cnt = '0;
  logic [7:0]  delay_min = '0;
  logic [7:0]  delay_max = '0;
  logic        rel_valid;
  logic [5:0]  rel_idx;
  logic [63:0] run_status;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #5 clk = ~clk;

  thread_release_seq u_thread_release_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_mask (enable_mask),
    .por_force   (por_force),
    .cycle_cnt   (cycle_cnt),
    .delay_min   (delay_min),
    .delay_max   (delay_max),
    .rel_valid   (rel_valid),
    .rel_idx     (rel_idx),
    .run_status  (run_status),
    .done        (done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic run_case(input logic [63:0] m, input int dmin, input int dmax, input bit por);
    int lowl[8];
    int lowc, ncen, n, last, ncyc, gate, deff, donecyc, idx, c, l, gap;
    logic [63:0] prev;
    logic [7:0] cseen;
    bit fin;
    lowc = -1; ncen = 0;
    for (int k = 0; k < 8; k++) begin
      lowl[k] = -1;
      for (int t = 7; t >= 0; t--) if (m[k*8+t]) lowl[k] = t;
      if (lowl[k] >= 0) begin
        ncen++;
        if (lowc < 0) lowc = k;
      end
    end
    gate = por ? 38 : 12;
    deff = (dmax < dmin) ? dmin : dmax;
    rst_n = 1'b0;
    enable_mask = m; por_force = por;
    delay_min = 8'(dmin); delay_max = 8'(dmax);
    cycle_cnt = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!rel_valid && run_status == '0 && !done, "R10 reset state", {run_status[61:0], done, rel_valid}, 64'd0);
    rst_n = 1'b1;
    n = 0; last = 0; ncyc = 0; donecyc = -1; fin = 1'b0;
    prev = '0; cseen = '0;
    while (!fin && ncyc < 6000) begin
      @(negedge clk);
      ncyc++;
      if (rel_valid) begin
        n++;
        idx = int'(rel_idx); c = idx / 8; l = idx % 8;
        chk(m[idx] == 1'b1, "R1 strobe names an enabled thread", 64'(idx), m);
        chk(prev[idx] == 1'b0, "R6 thread released only once", 64'(idx), prev);
        chk(run_status == (prev | (64'd1 << idx)), "R8 write-1-to-set of one bit", run_status, prev | (64'd1 << idx));
        if (n == 1) begin
          chk(int'(cycle_cnt) == gate + 1, "R2 first release at gate", 64'(cycle_cnt), 64'(gate + 1));
          chk(idx == lowc * 8 + lowl[lowc], "R4 first release", 64'(idx), 64'(lowc * 8 + lowl[lowc]));
          cseen[lowc] = 1'b1;
        end else begin
          gap = ncyc - last - 1;
          chk(gap >= dmin && gap <= deff, "R7 gap within bounds", 64'(gap), 64'(deff));
          if (n <= ncen) begin
            chk(c != lowc && !cseen[c] && l == lowl[c], "R5 core stage pick", 64'(idx), 64'(c * 8 + lowl[c]));
            cseen[c] = 1'b1;
          end else begin
            chk(cseen[c] && l != lowl[c], "R6 rest stage pick", 64'(idx), 64'(cseen));
          end
        end
        last = ncyc;
      end
      prev = run_status;
      if (done) begin
        fin = 1'b1;
        donecyc = int'(cycle_cnt);
      end
      if (cycle_cnt != 8'hFF) cycle_cnt = cycle_cnt + 8'd1;
    end
    chk(fin, "R9 done reached", 64'(fin), 64'd1);
    if (m == '0) begin
      // R3 empty mask
      chk(n == 0 && run_status == '0, "R3 no release for empty mask", 64'(n), 64'd0);
      chk(donecyc >= gate && donecyc <= gate + 1, "R3 done at gate", 64'(donecyc), 64'(gate));
    end else begin
      chk(n == $countones(m), "R6 release count", 64'(n), 64'($countones(m)));
      chk(run_status == m, "R9 status equals mask at done", run_status, m);
    end
    repeat (8) begin
      @(negedge clk);
      chk(done && !rel_valid && run_status == m, "R9 done held, no strobe", {run_status[61:0], done, rel_valid}, {m[61:0], 2'b10});
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    run_case(64'h0, 0, 0, 1'b0);
    run_case(64'h0, 2, 4, 1'b1);
    run_case(64'h1, 0, 0, 1'b0);
    run_case(64'h8000_0000_0000_0000, 2, 2, 1'b1);
    run_case('1, 0, 0, 1'b0);
    run_case('1, 1, 4, 1'b1);
    run_case(64'h0100_0000_0000_8000, 3, 3, 1'b0);
    run_case(64'h8040_2010_0804_0201, 0, 3, 1'b0);
    run_case(64'hF0F0_F0F0_F0F0_F0F0, 5, 2, 1'b0);
    run_case(64'hFF00_0000_0000_0000, 0, 1, 1'b1);
    for (int r = 0; r < 14; r++) begin
      logic [63:0] m;
      seed = next_rand(seed);
      m = seed;
      if (r % 3 == 1) m = m & next_rand(seed);
      seed = next_rand(seed);
      run_case(m, int'(seed[1:0]), int'(seed[6:4] % 6), seed[8]);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule